// File: doc/BRIEF.md
# Security Violation Status Capture Register

This block gathers the fault and misuse events of a cryptographic peripheral into a single 32-bit status word. Five event strobes feed it: a write-protection violation, a software misuse error, a private-key bus violation, an internal sequencer error and a clock-glitch detection pulse. A software error also carries a 4-bit type code and a warning/error class bit. The protection violation and the software error each carry the 16-bit register offset that was accessed.

Each flag is sticky until software reads the word. The read returns the whole word and clears it in the same access. The address field follows a priority rule. A protection violation always writes its offset into the field. A software error may only load its offset while no protection violation and no earlier software error is pending.

The bus access is a select strobe with a write qualifier. Only a select without the write qualifier counts as a read. Selects with the write qualifier change nothing.

Top module: `sec_viol_status`

## Requirements
- R1: The word layout is as follows. Bit 31 is the error class, where 0 means warning and 1 means error. Bits 27:24 hold the software error type. Bits 23:8 hold the captured offset. Bit 4 is the private-key flag, bit 3 the software-error flag, bit 2 the sequencer flag, bit 1 the clock-glitch flag and bit 0 the write-protection flag. Bits 30:28 and 7:5 always read 0.
- R2: After reset every field of the word is 0.
- R3: A one-cycle strobe on any of the five event inputs sets its flag. The flag stays at 1 until the next read, however many further events arrive.
- R4: A read (`acc_sel`=1, `acc_wr`=0) returns the word on `rd_data` in the same cycle and clears the whole word on that clock edge. Whenever no read is taking place, `rd_data` is 0.
- R5: A write-protection violation always loads its offset into bits 23:8. When several such violations happen between reads, the most recent one is held.
- R6: A software error loads its offset only when neither the write-protection flag nor the software-error flag is pending. A later protection violation replaces a software-error offset that is already held.
- R7: The type code (for example 5, meaning a start request before the keys are loaded) and the class bit of the first software error since the last read are held. Later software errors do not change them.
- R8: When a write-protection violation and a software error arrive in the same cycle, bits 23:8 take the protection violation's offset. The type and class still come from the software error.
- R9: When a read and an event fall in the same cycle, the read returns the old contents. The new event is recorded in the cleared word and is not lost.
- R10: An access with `acc_wr`=1 does not clear or alter the word, and it returns 0 on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_evt | input | 1 | Write-protection violation strobe |
| wp_addr | input | 16 | Offset of the protected register written |
| swe_evt | input | 1 | Software misuse error strobe |
| swe_type | input | 4 | Software error type code |
| swe_class | input | 1 | Software error class (1 = error) |
| swe_addr | input | 16 | Offset of the bad software access |
| pk_evt | input | 1 | Private-key bus violation strobe |
| seq_evt | input | 1 | Internal sequencer error strobe |
| glitch_evt | input | 1 | Clock-glitch detection pulse |
| acc_sel | input | 1 | Register access select |
| acc_wr | input | 1 | Access is a write (ignored) |
| rd_data | output | 32 | Status word during a read, else 0 |

## Verification
Two things can land on the same clock edge: the clear caused by a read, and the setting of a flag or capture of an address by a new event. Two address sources can also arrive on the same edge. The bench provokes the first case by asserting a read strobe in the same cycle as a new sequencer event. It then checks that the read shows only the older flag and that a second read shows only the new one. For the address race, it fires both address-carrying events together. It also fires them in both orders across cycles, and it compares the captured offset with the priority rule.

// File: rtl/svs_pkg.sv
package svs_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int TYPE_W    = 4;
    localparam int N_FLAGS   = 5;
    localparam int ADDR_LSB  = 8;
    localparam int TYPE_LSB  = 24;
    localparam int CLASS_BIT = 31;

    // flag vector positions, identical to the word's low bits
    localparam int F_WP     = 0;
    localparam int F_GLITCH = 1;
    localparam int F_SEQ    = 2;
    localparam int F_SWE    = 3;
    localparam int F_PK     = 4;

    typedef struct packed {
        logic              cls;
        logic [TYPE_W-1:0] typ;
    } swe_info_t;
endpackage

// File: rtl/svs_flag_bank.sv
module svs_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags_q
);
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = (clr ? '0 : flags_q) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/svs_addr_capture.sv
module svs_addr_capture #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wp_evt,
    input  logic [AW-1:0] wp_addr,
    input  logic          swe_evt,
    input  logic [AW-1:0] swe_addr,
    input  logic          wp_held,
    input  logic          swe_held,
    output logic [AW-1:0] addr_q
);
    logic [AW-1:0] addr_d;
    logic          wp_pend;
    logic          swe_pend;

    always_comb begin
        wp_pend  = wp_held  & ~clr;
        swe_pend = swe_held & ~clr;
        addr_d   = clr ? '0 : addr_q;
        if (wp_evt)
            addr_d = wp_addr;
        else if (swe_evt && !wp_pend && !swe_pend)
            addr_d = swe_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end
endmodule

// File: rtl/svs_swe_info.sv
module svs_swe_info
    import svs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              swe_evt,
    input  logic              swe_held,
    input  logic [TYPE_W-1:0] type_in,
    input  logic              class_in,
    output swe_info_t         info_q
);
    swe_info_t info_d;

    always_comb begin
        info_d = clr ? '0 : info_q;
        if (swe_evt && !(swe_held && !clr)) begin
            info_d.typ = type_in;
            info_d.cls = class_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) info_q <= '0;
        else        info_q <= info_d;
    end
endmodule

// File: rtl/sec_viol_status.sv
module sec_viol_status
    import svs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_evt,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic              swe_evt,
    input  logic [TYPE_W-1:0] swe_type,
    input  logic              swe_class,
    input  logic [ADDR_W-1:0] swe_addr,
    input  logic              pk_evt,
    input  logic              seq_evt,
    input  logic              glitch_evt,
    input  logic              acc_sel,
    input  logic              acc_wr,
    output logic [WORD_W-1:0] rd_data
);
    logic               rd_stb;
    logic [N_FLAGS-1:0] evt_vec;
    logic [N_FLAGS-1:0] flags_q;
    logic [ADDR_W-1:0]  addr_q;
    swe_info_t          info_q;
    logic [WORD_W-1:0]  status_word;

    assign rd_stb = acc_sel & ~acc_wr;

    always_comb begin
        evt_vec           = '0;
        evt_vec[F_WP]     = wp_evt;
        evt_vec[F_GLITCH] = glitch_evt;
        evt_vec[F_SEQ]    = seq_evt;
        evt_vec[F_SWE]    = swe_evt;
        evt_vec[F_PK]     = pk_evt;
    end

    svs_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rd_stb),
        .set     (evt_vec),
        .flags_q (flags_q)
    );

    svs_addr_capture #(.AW(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rd_stb),
        .wp_evt   (wp_evt),
        .wp_addr  (wp_addr),
        .swe_evt  (swe_evt),
        .swe_addr (swe_addr),
        .wp_held  (flags_q[F_WP]),
        .swe_held (flags_q[F_SWE]),
        .addr_q   (addr_q)
    );

    svs_swe_info u_info (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rd_stb),
        .swe_evt  (swe_evt),
        .swe_held (flags_q[F_SWE]),
        .type_in  (swe_type),
        .class_in (swe_class),
        .info_q   (info_q)
    );

    always_comb begin
        status_word                                = '0;
        status_word[N_FLAGS-1:0]                   = flags_q;
        status_word[ADDR_LSB +: ADDR_W]            = addr_q;
        status_word[TYPE_LSB +: TYPE_W]            = info_q.typ;
        status_word[CLASS_BIT]                     = info_q.cls;
    end

    assign rd_data = rd_stb ? status_word : '0;
endmodule

// File: rtl/svs_checker.sv
module svs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd,
    input logic        acc_sel,
    input logic        acc_wr,
    input logic        wp_evt,
    input logic [15:0] wp_addr,
    input logic        swe_evt,
    input logic [15:0] swe_addr,
    input logic        pk_evt,
    input logic        seq_evt,
    input logic        glitch_evt,
    input logic [31:0] status_word
);
    logic any_evt;
    assign any_evt = wp_evt | swe_evt | pk_evt | seq_evt | glitch_evt;

    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((status_word[4:0] & $past(status_word[4:0])) == $past(status_word[4:0])));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !any_evt) |=> (status_word == 32'd0));

    assert_wp_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wp_evt |=> (status_word[0] && status_word[23:8] == $past(wp_addr)));

    assert_swe_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swe_evt && !wp_evt && !rd && !status_word[0] && !status_word[3])
            |=> (status_word[23:8] == $past(swe_addr)));

    assert_swe_info_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && status_word[3]) |=> $stable({status_word[31], status_word[27:24]}));

    assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_wr && !any_evt) |=> $stable(status_word));
endmodule

bind sec_viol_status svs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd          (rd_stb),
    .acc_sel     (acc_sel),
    .acc_wr      (acc_wr),
    .wp_evt      (wp_evt),
    .wp_addr     (wp_addr),
    .swe_evt     (swe_evt),
    .swe_addr    (swe_addr),
    .pk_evt      (pk_evt),
    .seq_evt     (seq_evt),
    .glitch_evt  (glitch_evt),
    .status_word (status_word)
);

// File: tb/sec_viol_status_tb.sv
module sec_viol_status_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wp_evt = 0;
    logic [15:0] wp_addr = 0;
    logic        swe_evt = 0;
    logic [3:0]  swe_type = 0;
    logic        swe_class = 0;
    logic [15:0] swe_addr = 0;
    logic        pk_evt = 0;
    logic        seq_evt = 0;
    logic        glitch_evt = 0;
    logic        acc_sel = 0;
    logic        acc_wr = 0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    sec_viol_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .wp_evt(wp_evt), .wp_addr(wp_addr),
        .swe_evt(swe_evt), .swe_type(swe_type), .swe_class(swe_class), .swe_addr(swe_addr),
        .pk_evt(pk_evt), .seq_evt(seq_evt), .glitch_evt(glitch_evt),
        .acc_sel(acc_sel), .acc_wr(acc_wr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mkw(input logic cls, input logic [3:0] typ,
                                        input logic [15:0] addr, input logic [4:0] fl);
        mkw = {cls, 3'b000, typ, addr, 3'b000, fl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_evts();
        wp_evt = 0; swe_evt = 0; pk_evt = 0; seq_evt = 0; glitch_evt = 0;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        clear_evts();
        acc_sel = 0; acc_wr = 0;
    endtask

    task automatic do_read(output logic [31:0] val);
        @(negedge clk);
        acc_sel = 1; acc_wr = 0;
        #1 val = rd_data;
        end_cycle();
    endtask

    task automatic fire_wp(input logic [15:0] a);
        @(negedge clk);
        wp_evt = 1; wp_addr = a;
        end_cycle();
    endtask

    task automatic fire_swe(input logic [3:0] t, input logic c, input logic [15:0] a);
        @(negedge clk);
        swe_evt = 1; swe_type = t; swe_class = c; swe_addr = a;
        end_cycle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R4 idle rd_data", rd_data, 32'd0);
        do_read(v);
        check("R2 reset word", v, 32'd0);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        @(negedge clk); pk_evt = 1; end_cycle();
        @(negedge clk); seq_evt = 1; end_cycle();
        @(negedge clk); glitch_evt = 1; end_cycle();
        @(negedge clk); pk_evt = 1; end_cycle();
        repeat (3) @(negedge clk);
        do_read(v);
        check("R3 R1 sticky flags", v, mkw(0, 0, 0, 5'b10110));
        do_read(v);
        check("R4 clear after read", v, 32'd0);
    endtask

    task automatic t_wp_latest();
        logic [31:0] v;
        fire_wp(16'h00A4);
        fire_wp(16'h0C30);
        do_read(v);
        check("R5 latest wp offset", v, mkw(0, 0, 16'h0C30, 5'b00001));
    endtask

    task automatic t_swe_first();
        logic [31:0] v;
        fire_swe(4'd5, 1'b1, 16'h0040);
        fire_swe(4'd2, 1'b0, 16'h0FFC);
        do_read(v);
        check("R7 R6 first swe held", v, mkw(1, 4'd5, 16'h0040, 5'b01000));
    endtask

    task automatic t_swe_then_wp();
        logic [31:0] v;
        fire_swe(4'd0, 1'b0, 16'h0010);
        fire_wp(16'h0E4C);
        do_read(v);
        check("R6 wp overrides swe addr", v, mkw(0, 4'd0, 16'h0E4C, 5'b01001));
        fire_wp(16'h0200);
        fire_swe(4'd4, 1'b1, 16'h0300);
        do_read(v);
        check("R6 swe blocked by wp", v, mkw(1, 4'd4, 16'h0200, 5'b01001));
    endtask

    task automatic t_same_cycle_addr();
        logic [31:0] v;
        @(negedge clk);
        wp_evt = 1; wp_addr = 16'h1234;
        swe_evt = 1; swe_type = 4'd3; swe_class = 1'b0; swe_addr = 16'h5678;
        end_cycle();
        do_read(v);
        check("R8 simultaneous wp+swe", v, mkw(0, 4'd3, 16'h1234, 5'b01001));
    endtask

    task automatic t_read_race();
        logic [31:0] v;
        @(negedge clk); pk_evt = 1; end_cycle();
        @(negedge clk);
        acc_sel = 1; acc_wr = 0; seq_evt = 1;
        #1 v = rd_data;
        end_cycle();
        check("R9 read returns old", v, mkw(0, 0, 0, 5'b10000));
        do_read(v);
        check("R9 new event kept", v, mkw(0, 0, 0, 5'b00100));
        @(negedge clk);
        acc_sel = 1; acc_wr = 0;
        swe_evt = 1; swe_type = 4'd1; swe_class = 1'b0; swe_addr = 16'h0ABC;
        #1 v = rd_data;
        end_cycle();
        check("R9 read before swe", v, 32'd0);
        do_read(v);
        check("R9 swe kept in cleared word", v, mkw(0, 4'd1, 16'h0ABC, 5'b01000));
    endtask

    task automatic t_write_ignored();
        logic [31:0] v;
        @(negedge clk); glitch_evt = 1; end_cycle();
        @(negedge clk);
        acc_sel = 1; acc_wr = 1;
        #1 v = rd_data;
        end_cycle();
        check("R10 write returns zero", v, 32'd0);
        do_read(v);
        check("R10 write does not clear", v, mkw(0, 0, 0, 5'b00010));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_wp_latest();
        t_swe_first();
        t_swe_then_wp();
        t_same_cycle_addr();
        t_read_race();
        t_write_ignored();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule